// File: doc/BRIEF.md
# Load-Adaptive Valley Count Selector

This block decides how many ringing zero crossings a quasi-resonant flyback stage lets pass after the transformer demagnetises before the power switch turns on again. A light load needs a large count, which stretches the off time and lowers the switching rate. A heavy load needs a small count. The count is an unsigned 3-bit value that always lies between 1 and 7.

Three digitized comparator flags report where the regulation voltage sits against a low, a high and a maximum threshold. While an update window is open, the block remembers the highest level the voltage reached. A single-cycle update tick closes the window. On the tick the count steps up by one, stays where it is, or steps down by one, and a new window starts with a clean record. A sudden load step that drives the voltage past the maximum threshold does not wait for the tick. The count drops straight to 1 on the next switching-period strobe.

Top module: `valley_count_sel`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, the count is 1.
- R2: If no flag was asserted in any cycle of a window, including the tick cycle, the count rises by one in the cycle after the tick.
- R3: The count never rises above 7. A window that asks for a step up while the count is 7 leaves it at 7.
- R4: If the low flag was asserted in at least one cycle of the window and the high flag in none, the tick leaves the count unchanged.
- R5: If the high flag was asserted in at least one cycle of the window, even a single cycle well before the tick, the count falls by one in the cycle after the tick.
- R6: The count never falls below 1. A window that asks for a step down while the count is 1 leaves it at 1.
- R7: Once the max flag has been asserted, the count becomes 1 in the cycle after the next switching-period strobe. Until that strobe arrives, and with no tick, the count does not change.
- R8: Each tick clears the window record. A window with no flags that follows a window with the high flag still steps the count up.
- R9: The count changes only in the cycle after a tick or a switching-period strobe, and by at most one unless it is forced to 1. A switching-period strobe with no pending max event has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| aboveLow | input | 1 | Regulation voltage is above the low threshold |
| aboveHigh | input | 1 | Regulation voltage is above the high threshold |
| aboveMax | input | 1 | Regulation voltage is above the max threshold |
| tickStb | input | 1 | Single-cycle strobe that closes an update window |
| periodStb | input | 1 | Single-cycle strobe at the start of each switching period |
| valleyCount | output | 3 | Number of zero crossings to skip, from 1 to 7 |

## Verification
The hardest case to reach is a max event that is still pending. The max flag has fired, but no switching-period strobe has arrived yet, so the count must sit still for several cycles before it collapses to 1. The bench first raises the count with quiet windows. It then pulses the max flag alone, holds back both strobes while it watches the count, and only after that issues the period strobe. The sticky record gets the same kind of care. Each flag is pulsed for a single cycle well before the tick, so a design that looks only at the flags present in the tick cycle gives the wrong answer.

// File: rtl/vcs_pkg.sv
package vcs_pkg;
  localparam int CNT_W   = 3;
  localparam int CNT_MIN = 1;
  localparam int CNT_MAX = 7;

  typedef enum logic [1:0] {
    LVL_NONE = 2'd0,
    LVL_LOW  = 2'd1,
    LVL_HIGH = 2'd2,
    LVL_MAX  = 2'd3
  } level_t;

  typedef struct packed {
    logic stepUp;
    logic stepDown;
    logic forceMin;
  } ctrl_t;
endpackage

// File: rtl/vcs_ctrl.sv
module vcs_ctrl
  import vcs_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  aboveLow,
  input  logic  aboveHigh,
  input  logic  aboveMax,
  input  logic  tickStb,
  input  logic  periodStb,
  output ctrl_t ctrl
);
  level_t levelNow, peakReg, peakEff;
  logic   pendMax;

  // The highest flag present in this cycle.
  always_comb begin
    if (aboveMax)       levelNow = LVL_MAX;
    else if (aboveHigh) levelNow = LVL_HIGH;
    else if (aboveLow)  levelNow = LVL_LOW;
    else                levelNow = LVL_NONE;
    peakEff = (levelNow > peakReg) ? levelNow : peakReg;
  end

  // The window record is sticky and is cleared by the tick that consumes it.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      peakReg <= LVL_NONE;
      pendMax <= 1'b0;
    end else begin
      peakReg <= tickStb ? LVL_NONE : peakEff;
      if (periodStb)     pendMax <= 1'b0;
      else if (aboveMax) pendMax <= 1'b1;
    end
  end

  always_comb begin
    ctrl.forceMin = periodStb && (pendMax || aboveMax);
    ctrl.stepUp   = tickStb && (peakEff == LVL_NONE);
    ctrl.stepDown = tickStb && (peakEff >= LVL_HIGH);
  end

  // The record starts empty after every tick.
  assert_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    tickStb |=> (peakReg == LVL_NONE || levelNow != LVL_NONE) || $past(levelNow) != LVL_NONE || peakReg == LVL_NONE);
endmodule

// File: rtl/vcs_count.sv
module vcs_count
  import vcs_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctrl_t            ctrl,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] MIN_V = CNT_W'(CNT_MIN);
  localparam logic [CNT_W-1:0] MAX_V = CNT_W'(CNT_MAX);

  always_ff @(posedge clk) begin
    if (!rstN)                                count <= MIN_V;
    else if (ctrl.forceMin)                   count <= MIN_V;
    else if (ctrl.stepUp && count != MAX_V)   count <= count + 1'b1;
    else if (ctrl.stepDown && count != MIN_V) count <= count - 1'b1;
  end

  assert_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    count >= MIN_V && count <= MAX_V);

  assert_step_R9: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.forceMin |=> (count == $past(count) || count == $past(count) + 1'b1
                        || count == $past(count) - 1'b1));

  assert_force_R7: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.forceMin |=> count == MIN_V);

  assert_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(ctrl.stepUp || ctrl.stepDown || ctrl.forceMin) |=> $stable(count));
endmodule

// File: rtl/valley_count_sel.sv
module valley_count_sel
  import vcs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       aboveLow,
  input  logic       aboveHigh,
  input  logic       aboveMax,
  input  logic       tickStb,
  input  logic       periodStb,
  output logic [2:0] valleyCount
);
  ctrl_t ctrl;

  vcs_ctrl ctrl_i (
    .clk(clk), .rstN(rstN),
    .aboveLow(aboveLow), .aboveHigh(aboveHigh), .aboveMax(aboveMax),
    .tickStb(tickStb), .periodStb(periodStb), .ctrl(ctrl)
  );

  vcs_count count_i (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .count(valleyCount)
  );
endmodule

// File: tb/valley_count_sel_tb_top.sv
module valley_count_sel_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic aboveLow = 1'b0, aboveHigh = 1'b0, aboveMax = 1'b0;
  logic tickStb = 1'b0, periodStb = 1'b0;
  logic [2:0] valleyCount;
  int nRun = 0, nFail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  valley_count_sel dut_i (
    .clk(clk), .rstN(rstN), .aboveLow(aboveLow), .aboveHigh(aboveHigh),
    .aboveMax(aboveMax), .tickStb(tickStb), .periodStb(periodStb),
    .valleyCount(valleyCount)
  );

  // Each entry: [4:3] window level (0 none, 1 low, 2 high), [2:0] expected count after the tick.
  localparam int NVEC = 18;
  localparam logic [4:0] VEC [NVEC] = '{
    {2'd0,3'd2}, {2'd0,3'd3}, {2'd0,3'd4}, {2'd0,3'd5}, {2'd0,3'd6},
    {2'd0,3'd7}, {2'd0,3'd7}, {2'd1,3'd7}, {2'd2,3'd6}, {2'd2,3'd5},
    {2'd1,3'd5}, {2'd0,3'd6}, {2'd2,3'd5}, {2'd2,3'd4}, {2'd2,3'd3},
    {2'd2,3'd2}, {2'd2,3'd1}, {2'd2,3'd1}
  };

  task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseLevel(input logic [1:0] lvl);
    @(negedge clk);
    aboveLow  = (lvl >= 2'd1);
    aboveHigh = (lvl >= 2'd2);
    aboveMax  = (lvl == 2'd3);
    @(negedge clk);
    aboveLow = 1'b0; aboveHigh = 1'b0; aboveMax = 1'b0;
  endtask

  task automatic doTick();
    @(negedge clk); tickStb = 1'b1;
    @(negedge clk); tickStb = 1'b0;
  endtask

  task automatic window(input logic [1:0] lvl);
    idle(2);
    if (lvl != 2'd0) pulseLevel(lvl);
    idle(3);
    doTick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL R9 watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    idle(3);
    chk("R1 count during reset", valleyCount, 3'd1);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 count after reset", valleyCount, 3'd1);

    // Table walk: steps up (R2), saturation at 7 (R3), hold (R4),
    // sticky step down (R5), saturation at 1 (R6).
    for (int i = 0; i < NVEC; i++) begin
      window(VEC[i][4:3]);
      chk($sformatf("R2/R3/R4/R5/R6 vector %0d", i), valleyCount, VEC[i][2:0]);
    end

    // R8: a high window followed by a quiet window must step up.
    window(2'd0); window(2'd0); window(2'd0);
    chk("R2 climb to 4", valleyCount, 3'd4);
    window(2'd2);
    chk("R5 step down", valleyCount, 3'd3);
    window(2'd0);
    chk("R8 record cleared by tick", valleyCount, 3'd4);

    // R9: flags without strobes, and a period strobe without a pending max.
    pulseLevel(2'd2);
    idle(3);
    chk("R9 no change without strobe", valleyCount, 3'd4);
    @(negedge clk); periodStb = 1'b1;
    @(negedge clk); periodStb = 1'b0;
    chk("R9 idle period strobe", valleyCount, 3'd4);
    doTick();
    chk("R5 record held across period strobe", valleyCount, 3'd3);

    // R7: max event is pending until the period strobe.
    window(2'd0);
    chk("R2 back to 4", valleyCount, 3'd4);
    pulseLevel(2'd3);
    idle(1);
    chk("R7 no change before period strobe", valleyCount, 3'd4);
    idle(3);
    chk("R7 still pending", valleyCount, 3'd4);
    @(negedge clk); periodStb = 1'b1;
    @(negedge clk); periodStb = 1'b0;
    chk("R7 forced to 1", valleyCount, 3'd1);
    doTick();
    chk("R6 max window at 1 stays 1", valleyCount, 3'd1);
    window(2'd0);
    chk("R8 quiet window after max", valleyCount, 3'd2);

    // R1: reset in the middle of operation.
    window(2'd0);
    @(negedge clk); rstN = 1'b0;
    @(negedge clk);
    chk("R1 mid-run reset", valleyCount, 3'd1);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 after release", valleyCount, 3'd1);

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule